// File: doc/BRIEF.md
# Dual-Channel Interrupt Latch and Mask

This block is the interrupt front end of a two-channel disk interface card that sits on a byte-wide memory-mapped bus. Each channel has an enable flag. The flag is controlled by the kind of bus access made to the channel's enable offset, and the data value plays no part. A write of any byte sets the flag. A read of the same offset clears it and returns zero.

Each channel also has a status offset. Bit 0 of that offset reports the channel's drive interrupt line after synchronization. The card raises a single level-sensitive interrupt request when a channel is both enabled and has its synchronized line high. A separate pending output reports whether either line is high, whatever the enables hold, so that software can poll.

Software keeps a channel that has no drive attached masked. Its floating line then shows up only on the pending output and never on the card request.

Top module: `dual_irq_gate`

## Requirements
- R1: While rst_ni is low, both enables are 0, irq_o is 0 and rdata_o is 0x00.
- R2: A bus write (sel_i=1, we_i=1) of any data to 0x2200 sets the channel 0 enable, and a write to 0x3200 sets the channel 1 enable. The new value takes effect from the next clock edge, and the other channel's enable is left unchanged.
- R3: A bus read (sel_i=1, we_i=0) of 0x2200 clears the channel 0 enable, and a read of 0x3200 clears the channel 1 enable. The read returns 0x00.
- R4: A read of 0x2290 (channel 0) or 0x3290 (channel 1) returns the channel's synchronized interrupt in bit 0, with bits 7:1 equal to 0. Read data appears on rdata_o in the cycle after the access and is 0x00 in every other cycle.
- R5: irq_o is 1 exactly when some channel has its enable set and its synchronized interrupt high.
- R6: pending_o is 1 exactly when either synchronized interrupt is high, independent of the enables.
- R7: A change on drv_irq_i reaches the synchronized interrupt after two rising clock edges, not after one.
- R8: Cycles with sel_i=0, and accesses to any other address, leave both enables unchanged. Reads of other addresses return 0x00.
- R9: A status read leaves both enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 14 | Byte address |
| wdata_i | input | 8 | Write data (value unused) |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| drv_irq_i | input | 2 | Raw drive interrupt lines, asynchronous |
| irq_o | output | 1 | Card interrupt request, level |
| pending_o | output | 1 | Either synchronized line high |

## Verification
The bench goes after the access-type semantics. It writes zero data to an enable offset, which a design that decoded the data would ignore. It reads an enable offset while the line is high, which a design without the read-side clear would leave asserting irq_o. It reads status while a channel is enabled, which a design that decoded status reads too broadly would mask. A floating line on a masked channel must reach pending_o but not irq_o. Edge-by-edge probes of the synchronizer catch a design with one stage or with three stages.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] EN_BASE = 14'h2200;
  localparam logic [ADDR_W-1:0] ST_BASE = 14'h2290;
  localparam logic [ADDR_W-1:0] CH_STEP = 14'h1000;

  function automatic logic [ADDR_W-1:0] en_ofs(int k);
    return EN_BASE + ADDR_W'(k) * CH_STEP;
  endfunction

  function automatic logic [ADDR_W-1:0] st_ofs(int k);
    return ST_BASE + ADDR_W'(k) * CH_STEP;
  endfunction
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import dual_irq_pkg::*;
(
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NCH-1:0]    en_set_o,
  output logic [NCH-1:0]    en_clr_o,
  output logic [NCH-1:0]    st_rd_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic en_hit, st_hit;
    assign en_hit      = (addr_i == en_ofs(k));
    assign st_hit      = (addr_i == st_ofs(k));
    assign en_set_o[k] = sel_i &  we_i & en_hit;
    assign en_clr_o[k] = sel_i & ~we_i & en_hit;
    assign st_rd_o[k]  = sel_i & ~we_i & st_hit;
  end
endmodule

// File: rtl/irq_chan.sv
module irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic line_i,
  output logic en_o,
  output logic req_o
);
  logic en_q;

  // set and clear never coincide: they decode opposite access types
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= 1'b0;
    else if (set_i) en_q <= 1'b1;
    else if (clr_i) en_q <= 1'b0;
  end

  assign en_o  = en_q;
  assign req_o = en_q & line_i;
endmodule

// File: rtl/dual_irq_gate.sv
module dual_irq_gate
  import dual_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NCH-1:0]    drv_irq_i,
  output logic              irq_o,
  output logic              pending_o
);
  logic [NCH-1:0] irq_s, en_q, req, en_set, en_clr, st_rd;
  logic [DATA_W-1:0] rdata_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  irq_sync2 #(.W(NCH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (drv_irq_i),
    .q_o   (irq_s)
  );

  irq_addr_dec i_dec (
    .sel_i   (sel_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .en_set_o(en_set),
    .en_clr_o(en_clr),
    .st_rd_o (st_rd)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    irq_chan i_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (en_set[k]),
      .clr_i (en_clr[k]),
      .line_i(irq_s[k]),
      .en_o  (en_q[k]),
      .req_o (req[k])
    );
  end

  // enable-offset and unmapped reads return zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= {{(DATA_W-1){1'b0}}, |(st_rd & irq_s)};
  end

  assign rdata_o   = rdata_q;
  assign irq_o     = |req;
  assign pending_o = |irq_s;
endmodule

// File: rtl/dual_irq_gate_chk.sv
module dual_irq_gate_chk
  import dual_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              pending_o,
  input logic [NCH-1:0]    en_q,
  input logic [NCH-1:0]    irq_s
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (en_q == '0 && !irq_o && rdata_o == '0));

  for (genvar k = 0; k < NCH; k++) begin : g_k
    // R2
    en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && we_i && addr_i == en_ofs(k)) |=> en_q[k]);
    // R3
    en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && !we_i && addr_i == en_ofs(k)) |=> (!en_q[k] && rdata_o == '0));
    // R4
    st_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && !we_i && addr_i == st_ofs(k)) |=>
        (rdata_o == {{(DATA_W-1){1'b0}}, $past(irq_s[k])}));
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(en_q));
  // R9
  st_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && (addr_i == st_ofs(0) || addr_i == st_ofs(1))) |=> $stable(en_q));
  // R5
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
  // R6
  irq_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pending_o);
endmodule

bind dual_irq_gate dual_irq_gate_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .pending_o(pending_o),
  .en_q     (en_q),
  .irq_s    (irq_s)
);

// File: tb/test_dual_irq_gate.sv
module test_dual_irq_gate;
  localparam logic [13:0] EN0 = 14'h2200, EN1 = 14'h3200;
  localparam logic [13:0] ST0 = 14'h2290, ST1 = 14'h3290;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [13:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] drv = '0;
  logic irq, pend;

  int n_chk = 0, n_fail = 0;
  logic [1:0] men = '0, m1 = '0, m2 = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_irq_gate i_dual_irq_gate (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .drv_irq_i(drv), .irq_o(irq), .pending_o(pend)
  );

  // two-edge delay model of the lines (R7)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m1 <= '0; m2 <= '0; end
    else begin m1 <= drv; m2 <= m1; end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq(logic [1:0] e, logic [1:0] s);
    return |(e & s);
  endfunction

  task automatic check_outs();
    chk("R5 irq", irq, exp_irq(men, m2));
    chk("R6 pending", pend, |m2);
  endtask

  // one bus access; result sampled at the following falling edge
  task automatic op(logic s, logic w, logic [13:0] a, logic [7:0] d, logic [1:0] line);
    logic [7:0] exp_rd;
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d; drv = line;
    exp_rd = 8'h00;
    if (s && !w && a == ST0) exp_rd = {7'b0, m2[0]};
    if (s && !w && a == ST1) exp_rd = {7'b0, m2[1]};
    @(negedge clk);
    sel = 1'b0;
    if (s && a == EN0) men[0] = w;
    if (s && a == EN1) men[1] = w;
    if (s && !w) chk("R4/R3/R8 rdata", rdata, exp_rd);
    else         chk("R4 idle rdata", rdata, 8'h00);
    check_outs();
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); check_outs(); end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [13:0] a;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 irq", irq, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 pending", pend, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R7: probe edge by edge
    @(negedge clk); drv = 2'b01;
    @(negedge clk); chk("R7 one edge", pend, 0);
    @(negedge clk); chk("R7 two edges", pend, 1);
    chk("R5 masked", irq, 0);

    // R2 zero data still sets
    op(1, 1, EN0, 8'h00, 2'b01);
    chk("R2 set ch0", irq, 1);
    // R9 status read keeps enable
    op(1, 0, ST0, 8'h00, 2'b01);
    chk("R9 enable kept", irq, 1);
    // R3 read clears, returns 0
    op(1, 0, EN0, 8'h00, 2'b01);
    chk("R3 cleared", irq, 0);

    // R6/R8: masked floating channel 1
    op(1, 1, EN0, 8'hff, 2'b10);
    idle(3);
    chk("R6 float pending", pend, 1);
    chk("R8 float masked", irq, 0);
    // R8 strobe low write to EN1 ignored
    op(0, 1, EN1, 8'h5a, 2'b10);
    chk("R8 no strobe", irq, 0);
    op(1, 1, EN1 + 14'h1, 8'h5a, 2'b10);
    chk("R8 near addr", irq, 0);
    op(1, 1, EN1, 8'h01, 2'b10);
    idle(1);
    chk("R2 set ch1", irq, 1);

    // random mix
    for (int i = 0; i < 2000; i++) begin
      case ($urandom_range(0, 5))
        0: a = EN0; 1: a = EN1; 2: a = ST0; 3: a = ST1;
        default: a = 14'($urandom);
      endcase
      op(($urandom_range(0, 7) != 0), 1'($urandom), a, 8'($urandom), 2'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule